// File: doc/BRIEF.md
# Radix-2 Delay-Feedback FFT Stage

This block is one radix-2 stage of a streaming FFT built by cascading stages. A complex sample arrives with a valid flag on any clock. The stage pairs each sample with the one that arrived `SPAN` accepted samples later, using a feedback delay memory of `SPAN` words. A two-position switch decides what happens to each sample. In the straight position, incoming samples are parked in the memory, and the stage emits results left over from the previous block. In the crossed position, the butterfly runs. Its sum leaves at once. Its rotated difference is written back into the memory slot that was just read, and it leaves during the next straight period. The switch changes position every `SPAN` accepted samples.

The butterfly takes A (the stored, earlier sample) and B (the incoming, later sample). It forms the sum `(A + B)/2` and the difference `(A − B)·cis(π·k/SPAN)/2`, where k is the pair's position in the half-block. The twiddle values are produced at elaboration from `SPAN`. All arithmetic is 16-bit signed per component, with Q1.14 twiddles. Each output is halved with round-half-up so that it cannot grow without bound. The difference path is also clamped to the 16-bit range.

To build an N-point transform, chain log2(N) stages with spans N/2, N/4, …, 1, connecting `out_*` of one stage to `in_*` of the next. For each frame, the chain produces `sum_n x[n]·cis(+2π·n·m/N) / N` in bit-reversed order of m. Each stage delays the sample stream by its span, so the frame appears N−1 valid samples after it was entered, and a following frame flushes it out.

Top module: `fft_sdf_stage`

## Requirements
- R1: A synchronous active-low reset clears the switch to straight, the position counter and `out_valid`, and zeroes the delay memory. The first `SPAN` valid outputs after reset are therefore 0 + j0.
- R2: `out_valid` is `in_valid` delayed by exactly one clock. A cycle with `in_valid` low changes no counter, switch or memory state, so a stream with idle gaps produces the same outputs as the same stream with no gaps.
- R3: Number the accepted samples p = 0, 1, … from reset, and group them into blocks of 2·SPAN. For a sample at block position SPAN+k, the output registered with it is the sum of that sample and the one at block position k, computed per component as floor((A+B+1)/2).
- R4: For a sample at block position k (k < SPAN) in any block after the first, the output registered with it is the difference pair from the previous block, d = A − B. Per component it is re = (d_re·c − d_im·s + 2^14) >>> 15 and im = (d_re·s + d_im·c + 2^14) >>> 15, with (c, s) the twiddle for k.
- R5: `out_idx` is k for a sum output and SPAN+k for a difference output. The switch changes position after every SPAN accepted samples.
- R6: A difference component whose rounded value falls outside [−32768, 32767] is clamped to the nearer limit.
- R7: The twiddle for index k is c = round(cos(π·k/SPAN)·2^14) and s = round(sin(π·k/SPAN)·2^14), rounded to the nearest integer.
- R8: Four stages with spans 8, 4, 2, 1 fed with back-to-back 16-sample frames produce, for frame f, output element m at valid-output position 16·f + 15 + m. That element equals X[bitrev4(m)]/16, with X[q] = sum_n x[n]·cis(2π·n·q/16), to within 4 LSB per component.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_re | input | DATA_W | Input real part, signed |
| in_im | input | DATA_W | Input imaginary part, signed |
| out_valid | output | 1 | Output sample present |
| out_re | output | DATA_W | Output real part, signed |
| out_im | output | DATA_W | Output imaginary part, signed |
| out_idx | output | log2(2·SPAN) | Position of the output within its output block |

## Verification
In the crossed position, two things happen in one cycle. The stage emits a sum, and it reads and then overwrites the same memory slot with the rotated difference. In the straight position, it drains an old difference while parking the new sample in that slot. Every block of back-to-back samples exercises both overlaps. Idle gaps placed just before and just after a switch boundary stress them further. Each valid output is compared with a stream model in the bench, which is built from the pairing rules. Any difference that was overwritten too early or read too late shows up one block later as a wrong value or a wrong index.

// File: rtl/fft_sdf_stage.sv
module fft_sdf_stage #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16,
  parameter int SPAN   = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic signed [DATA_W-1:0]        in_re,
  input  logic signed [DATA_W-1:0]        in_im,
  output logic                            out_valid,
  output logic signed [DATA_W-1:0]        out_re,
  output logic signed [DATA_W-1:0]        out_im,
  output logic [$clog2(2*SPAN)-1:0]       out_idx
);

  localparam int AW    = (SPAN > 1) ? $clog2(SPAN) : 1;
  localparam int DEPTH = 1 << AW;
  localparam int IW    = $clog2(2 * SPAN);
  localparam int FRAC  = COEF_W - 2;
  localparam int PW    = DATA_W + COEF_W + 2;
  localparam logic signed [PW-1:0] HI = PW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [PW-1:0] LO = -HI - PW'(1);

  logic                     crossed;
  logic [AW-1:0]            ptr;
  logic signed [DATA_W-1:0] mem_re [DEPTH];
  logic signed [DATA_W-1:0] mem_im [DEPTH];
  logic signed [COEF_W-1:0] tw_c [DEPTH];
  logic signed [COEF_W-1:0] tw_s [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_twiddle
    localparam real ANG = 3.141592653589793 * k / SPAN;
    localparam int  CV  = $rtoi($floor($cos(ANG) * (1 << FRAC) + 0.5));
    localparam int  SV  = $rtoi($floor($sin(ANG) * (1 << FRAC) + 0.5));
    assign tw_c[k] = COEF_W'(CV);
    assign tw_s[k] = COEF_W'(SV);
  end

  logic signed [DATA_W-1:0] fb_re, fb_im;
  assign fb_re = mem_re[ptr];
  assign fb_im = mem_im[ptr];

  logic signed [DATA_W:0] sr, si, dr, di;
  assign sr = {fb_re[DATA_W-1], fb_re} + {in_re[DATA_W-1], in_re} + (DATA_W+1)'(1);
  assign si = {fb_im[DATA_W-1], fb_im} + {in_im[DATA_W-1], in_im} + (DATA_W+1)'(1);
  assign dr = {fb_re[DATA_W-1], fb_re} - {in_re[DATA_W-1], in_re};
  assign di = {fb_im[DATA_W-1], fb_im} - {in_im[DATA_W-1], in_im};

  logic signed [PW-1:0] pr, pi, qr, qi;
  assign pr = PW'(dr) * PW'(tw_c[ptr]) - PW'(di) * PW'(tw_s[ptr]);
  assign pi = PW'(dr) * PW'(tw_s[ptr]) + PW'(di) * PW'(tw_c[ptr]);
  assign qr = (pr + PW'(1 << FRAC)) >>> (FRAC + 1);
  assign qi = (pi + PW'(1 << FRAC)) >>> (FRAC + 1);

  function automatic logic signed [DATA_W-1:0] clamp(input logic signed [PW-1:0] v);
    if (v > HI)      return HI[DATA_W-1:0];
    else if (v < LO) return LO[DATA_W-1:0];
    else             return v[DATA_W-1:0];
  endfunction

  logic signed [DATA_W-1:0] wr_re, wr_im, res_re, res_im;
  assign wr_re  = crossed ? clamp(qr) : in_re;
  assign wr_im  = crossed ? clamp(qi) : in_im;
  assign res_re = crossed ? sr[DATA_W:1] : fb_re;
  assign res_im = crossed ? si[DATA_W:1] : fb_im;

  logic last;
  assign last = (ptr == AW'(SPAN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crossed   <= 1'b0;
      ptr       <= '0;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_idx   <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        mem_re[i] <= '0;
        mem_im[i] <= '0;
      end
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ptr         <= last ? '0 : ptr + AW'(1);
        crossed     <= last ? ~crossed : crossed;
        mem_re[ptr] <= wr_re;
        mem_im[ptr] <= wr_im;
        out_re      <= res_re;
        out_im      <= res_im;
        out_idx     <= crossed ? IW'(ptr) : IW'(SPAN) + IW'(ptr);
      end
    end
  end

  // R1: state leaving reset
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !$past(rst_n)) |-> (!out_valid && !crossed && ptr == '0));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(ptr) && $stable(crossed)));

  a_r5_switch_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && last) |=> (crossed != $past(crossed)));

  a_r5_switch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !last) |=> (crossed == $past(crossed)));

endmodule

// File: tb/fft_sdf_stage_tb.sv
module fft_sdf_stage_tb;

  localparam int  S  = 2;
  localparam real PI = 3.141592653589793;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic out_valid;
  logic signed [15:0] out_re, out_im;
  logic [1:0] out_idx;

  fft_sdf_stage #(.SPAN(S)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_idx(out_idx));

  logic ch_v = 1'b0;
  logic signed [15:0] ch_re = '0, ch_im = '0;
  logic [4:0] s_v;
  logic [4:0][15:0] s_re, s_im;
  assign s_v[0]  = ch_v;
  assign s_re[0] = ch_re;
  assign s_im[0] = ch_im;

  for (genvar i = 0; i < 4; i++) begin : g_chain
    localparam int SP = 8 >> i;
    logic [$clog2(2*SP)-1:0] idx;
    logic signed [15:0] o_re, o_im;
    fft_sdf_stage #(.SPAN(SP)) u_st (
      .clk(clk), .rst_n(rst_n), .in_valid(s_v[i]), .in_re(s_re[i]), .in_im(s_im[i]),
      .out_valid(s_v[i+1]), .out_re(o_re), .out_im(o_im), .out_idx(idx));
    assign s_re[i+1] = o_re;
    assign s_im[i+1] = o_im;
  end

  int n_checks = 0, n_fail = 0;
  int n_in = 0, n_got = 0, n_ch = 0;
  int st_re [256], st_im [256];
  int got_re [256], got_im [256], got_idx [256];
  int cr [128], ci [128];
  int fx_re [48], fx_im [48];

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && n_got < 256) begin
        got_re[n_got] = out_re; got_im[n_got] = out_im; got_idx[n_got] = out_idx;
        n_got++;
      end
      if (s_v[4] && n_ch < 128) begin
        cr[n_ch] = $signed(s_re[4]); ci[n_ch] = $signed(s_im[4]);
        n_ch++;
      end
    end
  end

  task automatic chk(string req, string what, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_tol(string req, string what, int got, real exp, real tol);
    n_checks++;
    if ((got - exp) > tol || (exp - got) > tol) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %f", req, what, got, exp);
    end
  endtask

  function automatic int tw(int k, int span, bit sine);
    real a = PI * k / span;
    return $rtoi($floor((sine ? $sin(a) : $cos(a)) * 16384.0 + 0.5));
  endfunction

  function automatic int rshift_round(longint p);
    return int'((p + 64'sd16384) >>> 15);
  endfunction

  function automatic int clamp16(int v, output bit hit);
    hit = (v > 32767) || (v < -32768);
    return (v > 32767) ? 32767 : (v < -32768) ? -32768 : v;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; ch_v = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_in = 0; n_got = 0; n_ch = 0;
  endtask

  task automatic push(int re, int im, int gap);
    @(negedge clk);
    in_valid = 1'b1; in_re = 16'(re); in_im = 16'(im);
    st_re[n_in] = re; st_im[n_in] = im; n_in++;
    repeat (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    in_valid = 1'b0; ch_v = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Stream model of one stage built from R1, R3, R4, R5, R6
  task automatic check_dut(string force_tag);
    for (int p = 0; p < n_got; p++) begin
      int r = p % (2 * S), b = p / (2 * S);
      int er, ei, eidx;
      string tag;
      if (r >= S) begin
        er = (st_re[p-S] + st_re[p] + 1) >>> 1;
        ei = (st_im[p-S] + st_im[p] + 1) >>> 1;
        eidx = r - S; tag = "R3";
      end else if (b == 0) begin
        er = 0; ei = 0; eidx = S + r; tag = "R1";
      end else begin
        int a = (b - 1) * 2 * S + r;
        longint dre = st_re[a] - st_re[a+S], dim = st_im[a] - st_im[a+S];
        int c = tw(r, S, 0), s = tw(r, S, 1);
        bit h1, h2;
        er = clamp16(rshift_round(dre * c - dim * s), h1);
        ei = clamp16(rshift_round(dre * s + dim * c), h2);
        eidx = S + r; tag = (h1 || h2) ? "R6" : "R4";
      end
      if (force_tag != "") tag = force_tag;
      chk(tag, $sformatf("re[%0d]", p), got_re[p], er);
      chk(tag, $sformatf("im[%0d]", p), got_im[p], ei);
      chk("R5", $sformatf("idx[%0d]", p), got_idx[p], eidx);
    end
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
    push(100, -200, 0); push(300, 400, 0);
    settle();
    chk("R1", "outputs seen", n_got, 2);
    check_dut("");
  endtask

  task automatic t_patterns();
    do_reset();
    for (int i = 0; i < 8; i++) push(i * 1000 - 3000, 500 - i * 700, 0);
    for (int i = 0; i < 8; i++) push((i % 2) ? 12000 : -12000, (i % 2) ? -9000 : 9000, 0);
    for (int i = 0; i < 8; i++) push(7, -7, 0);
    for (int i = 0; i < 4; i++) push(0, 0, 0);
    settle();
    chk("R2", "output count", n_got, n_in);
    check_dut("");
  endtask

  task automatic t_gaps();
    do_reset();
    for (int i = 0; i < 16; i++) push(i * 911 - 7000, 6000 - i * 577, i % 4);
    for (int i = 0; i < 4; i++) push(0, 0, (i == 1) ? 3 : 0);
    settle();
    chk("R2", "output count with gaps", n_got, n_in);
    check_dut("");
  endtask

  task automatic t_twiddle();
    do_reset();
    push(8192, 0, 0); push(8192, 0, 0); push(0, 0, 0); push(0, 0, 0);
    push(0, 0, 0); push(0, 0, 0); push(0, 0, 0); push(0, 0, 0);
    settle();
    chk("R7", "k=0 real", got_re[4], 4096);
    chk("R7", "k=0 imag", got_im[4], 0);
    chk("R7", "k=1 real", got_re[5], 0);
    chk("R7", "k=1 imag", got_im[5], 4096);
    check_dut("R7");
  endtask

  task automatic t_sat();
    do_reset();
    push(32767, -32768, 0); push(-32768, -32768, 0);
    push(-32768, 32767, 0); push(32767, 32767, 0);
    push(32767, 32767, 0);  push(-32768, -32768, 0);
    push(32767, 32767, 0);  push(-32768, -32768, 0);
    settle();
    chk("R6", "k=0 real clamped", got_re[4], 32767);
    chk("R6", "k=0 imag", got_im[4], -32767);
    chk("R6", "k=1 real clamped", got_re[5], 32767);
    chk("R3", "sum of max", got_re[6], 32767);
    chk("R3", "sum of min", got_re[7], -32768);
    check_dut("");
  endtask

  task automatic push_ch(int re, int im);
    @(negedge clk);
    ch_v = 1'b1; ch_re = 16'(re); ch_im = 16'(im);
  endtask

  task automatic t_fft();
    int unsigned lcg = 32'd12345;
    do_reset();
    for (int n = 0; n < 16; n++) begin
      fx_re[n] = (n == 3) ? 8000 : 0; fx_im[n] = 0;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      fx_re[16+n] = int'(lcg[30:16] % 8001) - 4000;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      fx_im[16+n] = int'(lcg[30:16] % 8001) - 4000;
      fx_re[32+n] = $rtoi($floor(3000.0 * $cos(2.0 * PI * 5 * n / 16) + 0.5));
      fx_im[32+n] = $rtoi($floor(3000.0 * $sin(2.0 * PI * 5 * n / 16) + 0.5));
    end
    for (int n = 0; n < 48; n++) push_ch(fx_re[n], fx_im[n]);
    for (int n = 0; n < 32; n++) push_ch(0, 0);
    settle();
    repeat (4) @(negedge clk);
    chk("R8", "chain output count", n_ch, 80);
    for (int f = 0; f < 3; f++) begin
      for (int m = 0; m < 16; m++) begin
        int q = {m[0], m[1], m[2], m[3]};
        real xr = 0.0, xi = 0.0;
        for (int n = 0; n < 16; n++) begin
          real a = 2.0 * PI * n * q / 16.0;
          xr += fx_re[16*f+n] * $cos(a) - fx_im[16*f+n] * $sin(a);
          xi += fx_re[16*f+n] * $sin(a) + fx_im[16*f+n] * $cos(a);
        end
        chk_tol("R8", $sformatf("frame %0d bin %0d re", f, q), cr[16*f+15+m], xr / 16.0, 4.0);
        chk_tol("R8", $sformatf("frame %0d bin %0d im", f, q), ci[16*f+15+m], xi / 16.0, 4.0);
      end
    end
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_patterns();
    t_gaps();
    t_twiddle();
    t_sat();
    t_fft();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule